// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

The block chooses which of a bank of transmit mailboxes a CAN controller sends next, and closes out each transmission when the bit engine reports it done. Each mailbox presents a 4-bit code, an identifier and a 3-bit local priority. The code, identifier and priority are held in an external mailbox store. The arbiter never writes them directly. It issues write-back strobes with an index, and the store applies them. A CPU write to a mailbox's control/status word is signalled by a per-mailbox strobe. The store shows the new code in the strobe cycle.

An arbitration run uses one of two priority rules. In identifier mode the lowest key wins. The key is the identifier, optionally preceded by the local priority bits as its most significant bits. In index mode the lowest mailbox index wins. The result is registered and offered to the bit engine with a valid signal. The engine takes it with a start pulse and reports the end with a done pulse. On a successful end the block stamps the time from a free-running timer, returns the code to inactive and raises a per-mailbox flag. The flags drive a masked interrupt request. Abort requests are handled the same way for mailboxes that are not in flight.

Top module: `can_tx_arbiter`

## Requirements
- R1: In identifier mode (`mode_idx`=0, `prio_en`=0) the eligible mailbox with the numerically lowest identifier wins; equal identifiers go to the lower index.
- R2: With `prio_en`=1 in identifier mode, the key is {local priority, identifier}, so a lower local priority wins regardless of the identifiers.
- R3: In index mode (`mode_idx`=1) the lowest-index eligible mailbox wins, whatever its identifier or local priority.
- R4: Only codes 4'b11xx are eligible. Code 4'b1000 (inactive), 4'b1001 (abort) and every code with bit 3 or bit 2 clear never win; with no eligible mailbox `tx_valid` is 0.
- R5: A mailbox whose `cs_wr` strobe is high is left out of any run in that cycle. Any `cs_wr` pulse or completion starts a new run one cycle later. `tx_valid` is 0 in the cycle after the strobe and shows the fresh winner in the cycle after that. Mode settings take effect at the next run.
- R6: A `tx_done` pulse while a mailbox is in flight ends the transmission. If the mailbox's code is not 4'b1000, the block does three things in the next cycle: it pulses `code_we` and `ts_we` with `wb_idx` set to the mailbox, sets `code_val` to 4'b1000 and `ts_val` to the `timer` value of the done cycle, and sets `iflag[wb_idx]`.
- R7: `irq` is high exactly when some `iflag` bit and the matching `irq_mask` bit are both set. A `flag_clr` bit clears its flag one cycle later.
- R8: With `abort_en`=1, a mailbox not in flight whose code is 4'b1001 gets a code write-back to 4'b1000 and its flag set, with no time-stamp write.
- R9: With `abort_en`=1, an abort code written to the mailbox in flight does not stop it; the done pulse then completes it as in R6.
- R10: With `abort_en`=0, code 4'b1001 causes no write-back and no flag. A mailbox in flight whose code was set to 4'b1000 finishes silently: no write-back and no flag.
- R11: `tx_start` while `tx_valid` is high makes the offered mailbox in flight. `tx_valid` stays 0 and `tx_idx` holds until the done pulse, even across CPU writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_idx | input | 1 | 1: index order, 0: identifier order |
| prio_en | input | 1 | Prefix local priority to the identifier key |
| abort_en | input | 1 | Enable abort handling of code 4'b1001 |
| mb_code | input | NUM_MB*4 | Code of each mailbox |
| mb_id | input | NUM_MB*ID_W | Identifier of each mailbox |
| mb_lprio | input | NUM_MB*3 | Local priority of each mailbox |
| cs_wr | input | NUM_MB | CPU control/status write strobes |
| flag_clr | input | NUM_MB | Write-1-to-clear for the flags |
| irq_mask | input | NUM_MB | Interrupt enable per mailbox |
| tx_start | input | 1 | Bit engine takes the offered mailbox |
| tx_done | input | 1 | Successful end of the transmission |
| timer | input | TS_W | Free-running timer |
| tx_valid | output | 1 | A fresh winner is offered |
| tx_idx | output | IDX_W | Offered or in-flight mailbox index |
| wb_idx | output | IDX_W | Mailbox of the write-back |
| code_we | output | 1 | Code write-back strobe |
| code_val | output | 4 | Code to write back (4'b1000) |
| ts_we | output | 1 | Time-stamp write strobe |
| ts_val | output | TS_W | Time stamp to write |
| iflag | output | NUM_MB | Per-mailbox flags |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench goes after identifier ties and the local-priority prefix. A design that got these wrong would pick the higher index, or order mailboxes by identifier alone. It checks that a result is held back for the cycle after a CPU write; a design without the re-run would offer a stale winner. It covers aborts in three cases: a mailbox that is idle, the mailbox in flight, and aborts with the feature disabled. Mistakes here would cut a transmission short, stamp a time on an aborted mailbox, or flag a silently deactivated one. Random rounds compare the winner with a bench model in both modes over mixed codes and crowded identifiers.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned LPRIO_W = 3;
    localparam logic [CODE_W-1:0] CODE_INACTIVE = 4'b1000;
    localparam logic [CODE_W-1:0] CODE_ABORT    = 4'b1001;

    // a transmit mailbox is pending when both upper code bits are set
    function automatic logic code_pending(input logic [CODE_W-1:0] c);
        return c[3] & c[2];
    endfunction
endpackage

// File: rtl/can_tx_arb_core.sv
module can_tx_arb_core #(
    parameter int unsigned N     = 32,
    parameter int unsigned KEY_W = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic [N-1:0]            elig,
    input  logic [N-1:0][KEY_W-1:0] keys,
    output logic                    found,
    output logic [IDX_W-1:0]        best_idx
);
    logic [KEY_W-1:0] best_key;

    // strict less-than keeps the lower index on equal keys
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_key = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (elig[i] && (!found || keys[i] < best_key)) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_key = keys[i];
            end
        end
    end
endmodule

// File: rtl/can_tx_first_set.sv
module can_tx_first_set #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
    import can_tx_pkg::*;
#(
    parameter int unsigned NUM_MB = 32,
    parameter int unsigned ID_W   = 29,
    parameter int unsigned TS_W   = 16,
    localparam int unsigned IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mode_idx,
    input  logic                              prio_en,
    input  logic                              abort_en,
    input  logic [NUM_MB-1:0][CODE_W-1:0]     mb_code,
    input  logic [NUM_MB-1:0][ID_W-1:0]       mb_id,
    input  logic [NUM_MB-1:0][LPRIO_W-1:0]    mb_lprio,
    input  logic [NUM_MB-1:0]                 cs_wr,
    input  logic [NUM_MB-1:0]                 flag_clr,
    input  logic [NUM_MB-1:0]                 irq_mask,
    input  logic                              tx_start,
    input  logic                              tx_done,
    input  logic [TS_W-1:0]                   timer,
    output logic                              tx_valid,
    output logic [IDX_W-1:0]                  tx_idx,
    output logic [IDX_W-1:0]                  wb_idx,
    output logic                              code_we,
    output logic [CODE_W-1:0]                 code_val,
    output logic                              ts_we,
    output logic [TS_W-1:0]                   ts_val,
    output logic [NUM_MB-1:0]                 iflag,
    output logic                              irq
);
    localparam int unsigned KEY_W = LPRIO_W + ID_W;

    typedef struct packed {
        logic [IDX_W-1:0]  win_idx;
        logic              win_vld;
        logic              inflight;
        logic              rearb;
        logic [NUM_MB-1:0] iflag;
        logic [IDX_W-1:0]  wb_idx;
        logic              code_we;
        logic              ts_we;
        logic [TS_W-1:0]   ts_val;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_MB-1:0]            excl;
    logic [NUM_MB-1:0]            elig;
    logic [NUM_MB-1:0]            abort_req;
    logic [NUM_MB-1:0][KEY_W-1:0] keys;
    logic                         pick_vld;
    logic [IDX_W-1:0]             pick_idx;
    logic                         abort_hit;
    logic [IDX_W-1:0]             abort_idx;
    logic                         accept;
    logic                         done_ok;
    logic                         silent;

    // per-mailbox key: zero in index mode so ties fall to the lowest index
    for (genvar g = 0; g < int'(NUM_MB); g++) begin : g_key
        always_comb begin
            if (mode_idx)
                keys[g] = '0;
            else if (prio_en)
                keys[g] = {mb_lprio[g], mb_id[g]};
            else
                keys[g] = {{LPRIO_W{1'b0}}, mb_id[g]};
        end
    end

    // mailboxes under a CPU write or under our own pending write-back sit out
    always_comb begin
        excl = cs_wr;
        if (state_q.code_we)
            excl[state_q.wb_idx] = 1'b1;
        for (int i = 0; i < int'(NUM_MB); i++) begin
            elig[i]      = code_pending(mb_code[i]) && !excl[i];
            abort_req[i] = abort_en && (mb_code[i] == CODE_ABORT) && !excl[i]
                           && !(state_q.inflight && (state_q.win_idx == IDX_W'(i)));
        end
    end

    can_tx_arb_core #(.N(NUM_MB), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_arb (
        .elig     (elig),
        .keys     (keys),
        .found    (pick_vld),
        .best_idx (pick_idx)
    );

    can_tx_first_set #(.N(NUM_MB), .IDX_W(IDX_W)) u_abort (
        .req (abort_req),
        .hit (abort_hit),
        .idx (abort_idx)
    );

    assign tx_valid = state_q.win_vld && !state_q.inflight && !state_q.rearb;
    assign accept   = tx_start && tx_valid;
    assign done_ok  = tx_done && state_q.inflight;
    assign silent   = (mb_code[state_q.win_idx] == CODE_INACTIVE);

    always_comb begin
        state_d         = state_q;
        state_d.code_we = 1'b0;
        state_d.ts_we   = 1'b0;
        state_d.iflag   = state_q.iflag & ~flag_clr;

        if (accept)
            state_d.inflight = 1'b1;

        if (done_ok) begin
            state_d.inflight = 1'b0;
            if (!silent) begin
                state_d.code_we                = 1'b1;
                state_d.ts_we                  = 1'b1;
                state_d.wb_idx                 = state_q.win_idx;
                state_d.ts_val                 = timer;
                state_d.iflag[state_q.win_idx] = 1'b1;
            end
        end else if (abort_hit) begin
            state_d.code_we          = 1'b1;
            state_d.wb_idx           = abort_idx;
            state_d.iflag[abort_idx] = 1'b1;
        end

        if (state_q.rearb && !state_q.inflight) begin
            state_d.win_vld = pick_vld;
            state_d.win_idx = pick_idx;
            state_d.rearb   = 1'b0;
        end

        if ((|cs_wr) || done_ok)
            state_d.rearb = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.rearb <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_idx   = state_q.win_idx;
    assign wb_idx   = state_q.wb_idx;
    assign code_we  = state_q.code_we;
    assign code_val = CODE_INACTIVE;
    assign ts_we    = state_q.ts_we;
    assign ts_val   = state_q.ts_val;
    assign iflag    = state_q.iflag;
    assign irq      = |(state_q.iflag & irq_mask);
endmodule

// File: rtl/can_tx_arb_chk.sv
module can_tx_arb_chk #(
    parameter int unsigned NUM_MB = 32,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_start,
    input logic              tx_done,
    input logic              tx_valid,
    input logic [IDX_W-1:0]  tx_idx,
    input logic [IDX_W-1:0]  wb_idx,
    input logic              code_we,
    input logic              ts_we,
    input logic [NUM_MB-1:0] iflag,
    input logic [NUM_MB-1:0] irq_mask,
    input logic              irq,
    input logic              inflight
);
    // R6: a time stamp is only written after a done pulse
    p_ts_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ts_we |-> $past(tx_done));

    // R6: a time stamp always travels with a code write-back
    p_ts_with_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ts_we |-> code_we);

    // R8: every code write-back leaves the mailbox flag set
    p_flag_on_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        code_we |-> iflag[wb_idx]);

    // R7: the request needs an enabled flag
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((iflag & irq_mask) != '0));

    // R11: a mailbox only goes in flight through an accepted start
    p_start_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inflight) |-> $past(tx_start && tx_valid));

    // R11: the in-flight index holds
    p_idx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight && $past(inflight)) |-> $stable(tx_idx));

    // R11: nothing is offered while a mailbox is in flight
    p_no_offer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inflight |-> !tx_valid);
endmodule

bind can_tx_arbiter can_tx_arb_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_start (tx_start),
    .tx_done  (tx_done),
    .tx_valid (tx_valid),
    .tx_idx   (tx_idx),
    .wb_idx   (wb_idx),
    .code_we  (code_we),
    .ts_we    (ts_we),
    .iflag    (iflag),
    .irq_mask (irq_mask),
    .irq      (irq),
    .inflight (state_q.inflight)
);

// File: tb/tb_can_tx_arbiter.sv
module tb_can_tx_arbiter;
    localparam int N    = 32;
    localparam int ID_W = 29;
    localparam int TS_W = 16;
    localparam int IW   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_idx = 1'b0, prio_en = 1'b0, abort_en = 1'b0;
    logic [N-1:0][3:0]      code_m;
    logic [N-1:0][ID_W-1:0] id_m;
    logic [N-1:0][2:0]      lp_m;
    logic [N-1:0] cs_wr = '0, flag_clr = '0, irq_mask = '0;
    logic tx_start = 1'b0, tx_done = 1'b0;
    logic [TS_W-1:0] tmr = '0;
    logic tx_valid, code_we, ts_we, irq;
    logic [IW-1:0] tx_idx, wb_idx;
    logic [3:0] code_val;
    logic [TS_W-1:0] ts_val;
    logic [N-1:0] iflag;

    int checks = 0, errors = 0, cyc = 0;
    int code_cnt [N];
    int ts_cnt [N];

    always #5 clk = ~clk;
    always @(posedge clk) tmr <= tmr + 1'b1;

    can_tx_arbiter #(.NUM_MB(N), .ID_W(ID_W), .TS_W(TS_W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_idx(mode_idx), .prio_en(prio_en),
        .abort_en(abort_en), .mb_code(code_m), .mb_id(id_m), .mb_lprio(lp_m),
        .cs_wr(cs_wr), .flag_clr(flag_clr), .irq_mask(irq_mask),
        .tx_start(tx_start), .tx_done(tx_done), .timer(tmr),
        .tx_valid(tx_valid), .tx_idx(tx_idx), .wb_idx(wb_idx), .code_we(code_we),
        .code_val(code_val), .ts_we(ts_we), .ts_val(ts_val), .iflag(iflag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle; the mailbox store applies write-backs here
    task automatic tick();
        @(negedge clk);
        if (code_we) begin
            code_m[wb_idx] = code_val;
            code_cnt[wb_idx]++;
        end
        if (ts_we) ts_cnt[wb_idx]++;
    endtask

    task automatic wr_code(input int i, input logic [3:0] c);
        code_m[i] = c;
        cs_wr[i]  = 1'b1;
        tick();
        cs_wr = '0;
    endtask

    function automatic int exp_win();
        bit found = 0;
        int best = -1;
        logic [31:0] bk = '0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] k;
            if (mode_idx) k = '0;
            else if (prio_en) k = {lp_m[i], id_m[i]};
            else k = {3'b000, id_m[i]};
            if (code_m[i][3] && code_m[i][2] && (!found || k < bk)) begin
                found = 1; best = i; bk = k;
            end
        end
        return best;
    endfunction

    task automatic chk_win(input string req);
        int e = exp_win();
        chk(tx_valid == (e >= 0), req, int'(tx_valid), int'(e >= 0));
        if (e >= 0) chk(int'(tx_idx) == e, req, int'(tx_idx), e);
    endtask

    function automatic logic [3:0] rnd_code();
        case ($urandom_range(0, 7))
            0: return 4'b1100;
            1: return 4'b1101;
            2: return 4'b1110;
            3: return 4'b1111;
            4: return 4'b1000;
            5: return 4'b1001;
            6: return 4'b0000;
            default: return 4'b0100;
        endcase
    endfunction

    // run a transmission of the offered mailbox, return its index
    task automatic start_tx(output int w);
        w = int'(tx_idx);
        tx_start = 1'b1;
        tick();
        tx_start = 1'b0;
    endtask

    task automatic finish_tx(output int ts_exp);
        tx_done = 1'b1;
        ts_exp = int'(tmr);
        tick();
        tx_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w, w2, tse, d0;
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            code_m[i] = 4'b1000; id_m[i] = '0; lp_m[i] = '0;
            code_cnt[i] = 0; ts_cnt[i] = 0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        tick(); tick();
        // R4: reset state with all mailboxes inactive
        chk(tx_valid == 1'b0, "R4 reset valid", int'(tx_valid), 0);
        chk(iflag == '0, "R7 reset flags", int'(iflag), 0);
        chk(irq == 1'b0, "R7 reset irq", int'(irq), 0);

        // R1: identifier order with a tie
        id_m[3] = 29'h10; id_m[5] = 29'h10; id_m[9] = 29'h5;
        lp_m[3] = 3'd3; lp_m[5] = 3'd1; lp_m[9] = 3'd7;
        code_m[3] = 4'b1100; code_m[5] = 4'b1100;
        wr_code(9, 4'b1100);
        // R5: no offer in the cycle after the write
        chk(tx_valid == 1'b0, "R5 hold after write", int'(tx_valid), 0);
        tick();
        chk(tx_valid && tx_idx == 5'd9, "R1 lowest id", int'(tx_idx), 9);
        wr_code(9, 4'b1000);
        tick();
        chk(tx_valid && tx_idx == 5'd3, "R1 tie lower index", int'(tx_idx), 3);
        // R4: abort code is not eligible
        wr_code(9, 4'b1001);
        tick();
        chk(tx_idx == 5'd3, "R4 abort code skipped", int'(tx_idx), 3);
        chk(code_cnt[9] == 0 && iflag[9] == 1'b0, "R10 abort ignored when disabled",
            int'(iflag[9]), 0);
        wr_code(9, 4'b1100);
        tick();

        // R2: local priority leads the key
        prio_en = 1'b1;
        wr_code(0, 4'b1000);
        tick();
        chk(tx_valid && tx_idx == 5'd5, "R2 local priority", int'(tx_idx), 5);
        // R3: index order
        mode_idx = 1'b1;
        wr_code(0, 4'b1000);
        tick();
        chk(tx_valid && tx_idx == 5'd3, "R3 index order", int'(tx_idx), 3);
        prio_en = 1'b0; mode_idx = 1'b0;

        // R11 and R6: transmit mailbox 9 (lowest id)
        wr_code(0, 4'b1000);
        tick();
        start_tx(w);
        chk(w == 9, "R1 winner before start", w, 9);
        chk(tx_valid == 1'b0, "R11 no offer in flight", int'(tx_valid), 0);
        wr_code(3, 4'b1100);
        tick();
        chk(tx_idx == 5'd9, "R11 index holds", int'(tx_idx), 9);
        irq_mask[9] = 1'b1;
        finish_tx(tse);
        chk(code_we && ts_we && wb_idx == 5'd9, "R6 write-back strobes", int'(wb_idx), 9);
        chk(int'(ts_val) == tse, "R6 time stamp", int'(ts_val), tse);
        chk(code_val == 4'b1000, "R6 code inactive", int'(code_val), 8);
        chk(iflag[9] == 1'b1, "R6 flag set", int'(iflag[9]), 1);
        chk(irq == 1'b1, "R7 irq masked on", int'(irq), 1);
        tick(); tick();
        chk(tx_valid && tx_idx == 5'd3, "R5 rerun after completion", int'(tx_idx), 3);
        flag_clr[9] = 1'b1;
        tick();
        flag_clr = '0;
        chk(iflag[9] == 1'b0 && irq == 1'b0, "R7 flag clear", int'(irq), 0);
        // R7: flag without mask gives no request
        start_tx(w);
        finish_tx(tse);
        chk(iflag[w] == 1'b1 && irq == 1'b0, "R7 unmasked flag", int'(irq), 0);
        tick(); tick();

        // R8: abort of an idle mailbox
        abort_en = 1'b1;
        d0 = ts_cnt[5];
        wr_code(5, 4'b1001);
        tick();
        chk(code_m[5] == 4'b1000, "R8 abort code", int'(code_m[5]), 8);
        chk(iflag[5] == 1'b1, "R8 abort flag", int'(iflag[5]), 1);
        chk(ts_cnt[5] == d0, "R8 no time stamp", ts_cnt[5], d0);

        // R9: abort of the mailbox in flight
        code_m[20] = 4'b1100; id_m[20] = 29'h1;
        wr_code(20, 4'b1100);
        tick();
        start_tx(w);
        chk(w == 20, "R9 winner", w, 20);
        d0 = code_cnt[20];
        wr_code(20, 4'b1001);
        tick(); tick();
        chk(code_cnt[20] == d0 && tx_idx == 5'd20, "R9 no early abort", code_cnt[20], d0);
        finish_tx(tse);
        chk(ts_we && wb_idx == 5'd20 && int'(ts_val) == tse, "R9 completes", int'(ts_val), tse);
        tick(); tick();

        // R10: silent deactivation while in flight
        abort_en = 1'b0;
        flag_clr = '1;
        tick();
        flag_clr = '0;
        wr_code(21, 4'b1100);
        id_m[21] = 29'h0;
        wr_code(21, 4'b1100);
        tick();
        start_tx(w);
        chk(w == 21, "R10 winner", w, 21);
        d0 = code_cnt[21];
        wr_code(21, 4'b1000);
        tick();
        finish_tx(tse);
        tick();
        chk(code_cnt[21] == d0 && iflag[21] == 1'b0, "R10 silent finish", int'(iflag[21]), 0);

        // R1 R2 R3 R4: random rounds against the model
        for (int r = 0; r < 60; r++) begin
            mode_idx = ($urandom_range(0, 2) == 0);
            prio_en  = $urandom_range(0, 1);
            for (int i = 0; i < N; i++) begin
                code_m[i] = rnd_code();
                id_m[i]   = (r % 2 == 0) ? ID_W'($urandom_range(0, 3)) : ID_W'($urandom);
                lp_m[i]   = 3'($urandom_range(0, 7));
            end
            cs_wr = '1;
            tick();
            cs_wr = '0;
            tick();
            chk_win(mode_idx ? "R3 random" : (prio_en ? "R2 random" : "R1 random"));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule